// File: doc/BRIEF.md
# Lane Bifurcation Mapper

This block sits between sixteen physical lanes and two link controllers, A and B, at the logical level after the PHY. Every lane carries a data word and a valid bit in each direction. On the controller side, A has sixteen logical lanes and B has eight. The block steers each lane between the two sides according to a lane-split configuration. That configuration is read once from three strap inputs when reset is released.

Four layouts exist:

- one sixteen-lane link, in forward or mirrored lane order;
- two eight-lane links, again in forward or mirrored order.

In the mirrored split, the two controllers swap their halves of the physical lanes, and each half is also reversed. Lanes that a layout does not use stay idle. A strap pattern that does not enable the port raises an error flag, and the block falls back to the forward sixteen-lane layout. The chosen layout is reported as a two-bit code together with a mask of the active controllers.

Top module: `lane_bifurcation_mapper`

## Requirements
- R1: While `rst` is high, `mode` is 0, `ctrl_active` is 2'b01 and `strap_err` is 0. All lane data and valid outputs are zero, whatever the straps are.
- R2: The straps are captured at the first rising clock edge with `rst` low. Strap changes after that point do not alter `mode`, `ctrl_active`, `strap_err` or the lane mapping until the next reset.
- R3: Strap bits `strap[2]` (port enable), `strap[1]` (1 = single wide link) and `strap[0]` (1 = forward order) equal to 3'b111 select mode 0. In mode 0, physical lane i exchanges with A lane i in both directions.
- R4: Straps 3'b110 select mode 1. Physical lane i exchanges with A lane 15-i.
- R5: Straps 3'b101 select mode 2. Physical lanes 0..7 exchange with A lanes 0..7, and physical lanes 8..15 exchange with B lanes 0..7.
- R6: Straps 3'b100 select mode 3. Physical lane i (0..7) exchanges with B lane 7-i, and physical lane i (8..15) exchanges with A lane 15-i.
- R7: In modes 0 and 1, the B receive outputs stay at zero data with valid low, and the B transmit inputs have no effect on any physical lane.
- R8: In modes 2 and 3, A receive lanes 8..15 stay at zero data with valid low, and A transmit lanes 8..15 have no effect on any physical lane.
- R9: Any strap value with `strap[2]` = 0 sets `strap_err` to 1 and applies the mode 0 mapping. `strap_err` is 0 for the four valid values.
- R10: A data word and its valid bit appear on the mapped lane exactly one clock edge after they are presented, in both directions.
- R11: `ctrl_active` is 2'b01 (bit 0 = A, bit 1 = B) in modes 0 and 1, and 2'b11 in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 3 | [2] port enable, [1] single wide link, [0] forward lane order |
| a_tx_data | input | 16x8 | Controller A transmit data, per logical lane |
| a_tx_valid | input | 16 | Controller A transmit valid, per logical lane |
| b_tx_data | input | 8x8 | Controller B transmit data, per logical lane |
| b_tx_valid | input | 8 | Controller B transmit valid, per logical lane |
| phy_tx_data | output | 16x8 | Transmit data, per physical lane |
| phy_tx_valid | output | 16 | Transmit valid, per physical lane |
| phy_rx_data | input | 16x8 | Receive data, per physical lane |
| phy_rx_valid | input | 16 | Receive valid, per physical lane |
| a_rx_data | output | 16x8 | Controller A receive data |
| a_rx_valid | output | 16 | Controller A receive valid |
| b_rx_data | output | 8x8 | Controller B receive data |
| b_rx_valid | output | 8 | Controller B receive valid |
| mode | output | 2 | Decoded layout code 0..3 |
| ctrl_active | output | 2 | Enabled controllers, bit 0 = A, bit 1 = B |
| strap_err | output | 1 | Strap pattern did not enable the port |

## Verification
The configuration outputs change at the first rising edge after `rst` falls. The bench therefore releases reset on a falling edge and reads `mode`, `ctrl_active` and `strap_err` one falling edge later. Lane outputs lag their inputs by exactly one rising edge. Stimulus is applied on a falling edge and compared on the next falling edge. One directed check also reads just before the rising edge, to confirm the previous word is still present. The "no effect" checks change only the ignored inputs and then compare the outputs one edge later against the values from before the change.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    // Layout code presented on the mode output
    typedef enum logic [1:0] {
        MODE_X16      = 2'd0,
        MODE_X16_REV  = 2'd1,
        MODE_X8X8     = 2'd2,
        MODE_X8X8_REV = 2'd3
    } bif_mode_e;

    // Strap inputs as seen on the strap port
    typedef struct packed {
        logic port_en;   // 0 = illegal combination
        logic single;    // 1 = one wide link, 0 = two half links
        logic fwd;       // 1 = forward lane order, 0 = mirrored
    } strap_t;

    // Latched configuration
    typedef struct packed {
        bif_mode_e  mode;
        logic [1:0] active;  // bit0 = A, bit1 = B
        logic       err;
    } bif_cfg_t;

    localparam bif_cfg_t CFG_RESET = '{mode: MODE_X16, active: 2'b01, err: 1'b0};

    function automatic logic mode_is_split(bif_mode_e m);
        return m == MODE_X8X8 || m == MODE_X8X8_REV;
    endfunction

    function automatic bif_cfg_t decode_strap(strap_t s);
        bif_cfg_t c;
        c = CFG_RESET;
        if (!s.port_en) begin
            c.err = 1'b1;
        end else begin
            unique case ({s.single, s.fwd})
                2'b11:   c.mode = MODE_X16;
                2'b10:   c.mode = MODE_X16_REV;
                2'b01:   c.mode = MODE_X8X8;
                default: c.mode = MODE_X8X8_REV;
            endcase
            c.active = mode_is_split(c.mode) ? 2'b11 : 2'b01;
        end
        return c;
    endfunction

endpackage

// File: rtl/lbm_strap_latch.sv
module lbm_strap_latch
    import lbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  strap_t   strap,
    output bif_cfg_t cfg,
    output logic     latched
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= CFG_RESET;
            latched <= 1'b0;
        end else if (!latched) begin
            cfg     <= decode_strap(strap);
            latched <= 1'b1;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(latched) |-> $stable(cfg));                                    // R2

    AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        cfg.err |-> (cfg.mode == MODE_X16 && cfg.active == 2'b01));          // R9

    AST_ERR_FROM_STRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(latched) |-> (cfg.err == !$past(strap.port_en)));              // R9

    AST_MASK_MATCH: assert property (@(posedge clk) disable iff (rst)
        cfg.active == (mode_is_split(cfg.mode) ? 2'b11 : 2'b01));            // R11

endmodule

// File: rtl/lbm_tx_xbar.sv
module lbm_tx_xbar
    import lbm_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int DATA_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  bif_mode_e                          mode,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]   a_data,
    input  logic [NUM_LANES-1:0]               a_valid,
    input  logic [NUM_LANES/2-1:0][DATA_W-1:0] b_data,
    input  logic [NUM_LANES/2-1:0]             b_valid,
    output logic [NUM_LANES-1:0][DATA_W-1:0]   phy_data,
    output logic [NUM_LANES-1:0]               phy_valid
);

    localparam int HALF = NUM_LANES / 2;

    for (genvar p = 0; p < NUM_LANES; p++) begin : g_phy
        localparam int MIR = NUM_LANES - 1 - p;
        logic [DATA_W-1:0] d_nxt;
        logic              v_nxt;

        if (p < HALF) begin : g_lo
            localparam int BMIR = HALF - 1 - p;
            always_comb begin
                case (mode)
                    MODE_X16:     begin d_nxt = a_data[p];    v_nxt = a_valid[p];    end
                    MODE_X16_REV: begin d_nxt = a_data[MIR];  v_nxt = a_valid[MIR];  end
                    MODE_X8X8:    begin d_nxt = a_data[p];    v_nxt = a_valid[p];    end
                    default:      begin d_nxt = b_data[BMIR]; v_nxt = b_valid[BMIR]; end
                endcase
            end
        end else begin : g_hi
            localparam int BIDX = p - HALF;
            always_comb begin
                case (mode)
                    MODE_X16:     begin d_nxt = a_data[p];    v_nxt = a_valid[p];    end
                    MODE_X16_REV: begin d_nxt = a_data[MIR];  v_nxt = a_valid[MIR];  end
                    MODE_X8X8:    begin d_nxt = b_data[BIDX]; v_nxt = b_valid[BIDX]; end
                    default:      begin d_nxt = a_data[MIR];  v_nxt = a_valid[MIR];  end
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                phy_data[p]  <= '0;
                phy_valid[p] <= 1'b0;
            end else begin
                phy_data[p]  <= d_nxt;
                phy_valid[p] <= v_nxt;
            end
        end
    end

    AST_TX_X16_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == MODE_X16) |-> (phy_valid == $past(a_valid)));   // R10

    AST_TX_X16REV_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == MODE_X16_REV) |->
            (phy_data[0] == $past(a_data[NUM_LANES-1])));                              // R4

    AST_TX_X8_UPPER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == MODE_X8X8) |->
            (phy_valid[NUM_LANES-1:HALF] == $past(b_valid)));                          // R5

endmodule

// File: rtl/lbm_rx_xbar.sv
module lbm_rx_xbar
    import lbm_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int DATA_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  bif_mode_e                          mode,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]   phy_data,
    input  logic [NUM_LANES-1:0]               phy_valid,
    output logic [NUM_LANES-1:0][DATA_W-1:0]   a_data,
    output logic [NUM_LANES-1:0]               a_valid,
    output logic [NUM_LANES/2-1:0][DATA_W-1:0] b_data,
    output logic [NUM_LANES/2-1:0]             b_valid
);

    localparam int HALF = NUM_LANES / 2;

    // Controller A: all sixteen logical lanes
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_a
        localparam int MIR = NUM_LANES - 1 - l;
        logic [DATA_W-1:0] d_nxt;
        logic              v_nxt;

        if (l < HALF) begin : g_lo
            always_comb begin
                case (mode)
                    MODE_X16, MODE_X8X8: begin d_nxt = phy_data[l];   v_nxt = phy_valid[l];   end
                    default:             begin d_nxt = phy_data[MIR]; v_nxt = phy_valid[MIR]; end
                endcase
            end
        end else begin : g_hi
            always_comb begin
                case (mode)
                    MODE_X16:     begin d_nxt = phy_data[l];   v_nxt = phy_valid[l];   end
                    MODE_X16_REV: begin d_nxt = phy_data[MIR]; v_nxt = phy_valid[MIR]; end
                    default:      begin d_nxt = '0;            v_nxt = 1'b0;           end
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                a_data[l]  <= '0;
                a_valid[l] <= 1'b0;
            end else begin
                a_data[l]  <= d_nxt;
                a_valid[l] <= v_nxt;
            end
        end
    end

    // Controller B: eight logical lanes, live only in split layouts
    for (genvar l = 0; l < HALF; l++) begin : g_b
        localparam int UP  = HALF + l;
        localparam int MIR = HALF - 1 - l;
        logic [DATA_W-1:0] d_nxt;
        logic              v_nxt;

        always_comb begin
            case (mode)
                MODE_X8X8:     begin d_nxt = phy_data[UP];  v_nxt = phy_valid[UP];  end
                MODE_X8X8_REV: begin d_nxt = phy_data[MIR]; v_nxt = phy_valid[MIR]; end
                default:       begin d_nxt = '0;            v_nxt = 1'b0;           end
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                b_data[l]  <= '0;
                b_valid[l] <= 1'b0;
            end else begin
                b_data[l]  <= d_nxt;
                b_valid[l] <= v_nxt;
            end
        end
    end

    AST_RX_B_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !mode_is_split($past(mode))) |-> (b_valid == '0 && b_data == '0));   // R7

    AST_RX_A_UPPER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_is_split($past(mode))) |-> (a_valid[NUM_LANES-1:HALF] == '0));  // R8

    AST_RX_X8REV_B0: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == MODE_X8X8_REV) |->
            (b_data[0] == $past(phy_data[HALF-1]) && b_valid[0] == $past(phy_valid[HALF-1])));  // R6

    AST_RX_X16_LANE0: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == MODE_X16) |-> (a_data[0] == $past(phy_data[0])));      // R3

endmodule

// File: rtl/lane_bifurcation_mapper.sv
module lane_bifurcation_mapper
    import lbm_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int DATA_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [2:0]                         strap,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]   a_tx_data,
    input  logic [NUM_LANES-1:0]               a_tx_valid,
    input  logic [NUM_LANES/2-1:0][DATA_W-1:0] b_tx_data,
    input  logic [NUM_LANES/2-1:0]             b_tx_valid,
    output logic [NUM_LANES-1:0][DATA_W-1:0]   phy_tx_data,
    output logic [NUM_LANES-1:0]               phy_tx_valid,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]   phy_rx_data,
    input  logic [NUM_LANES-1:0]               phy_rx_valid,
    output logic [NUM_LANES-1:0][DATA_W-1:0]   a_rx_data,
    output logic [NUM_LANES-1:0]               a_rx_valid,
    output logic [NUM_LANES/2-1:0][DATA_W-1:0] b_rx_data,
    output logic [NUM_LANES/2-1:0]             b_rx_valid,
    output logic [1:0]                         mode,
    output logic [1:0]                         ctrl_active,
    output logic                               strap_err
);

    bif_cfg_t cfg;
    logic     cfg_latched;

    lbm_strap_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .strap   (strap_t'(strap)),
        .cfg     (cfg),
        .latched (cfg_latched)
    );

    lbm_tx_xbar #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg.mode),
        .a_data    (a_tx_data),
        .a_valid   (a_tx_valid),
        .b_data    (b_tx_data),
        .b_valid   (b_tx_valid),
        .phy_data  (phy_tx_data),
        .phy_valid (phy_tx_valid)
    );

    lbm_rx_xbar #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg.mode),
        .phy_data  (phy_rx_data),
        .phy_valid (phy_rx_valid),
        .a_data    (a_rx_data),
        .a_valid   (a_rx_valid),
        .b_data    (b_rx_data),
        .b_valid   (b_rx_valid)
    );

    assign mode        = cfg.mode;
    assign ctrl_active = cfg.active;
    assign strap_err   = cfg.err;

    AST_RESET_CFG: assert property (@(posedge clk)
        $past(rst) |-> (mode == 2'd0 && ctrl_active == 2'b01 && !strap_err)) // R1
        else if (!cfg_latched) ;

endmodule

// File: tb/tb_lane_bifurcation_mapper.sv
`timescale 1ns/1ps
module tb_lane_bifurcation_mapper;

    localparam int NL   = 16;
    localparam int HL   = NL / 2;
    localparam int W    = 8;

    typedef logic [NL-1:0][W-1:0] ldat_t;
    typedef logic [NL-1:0]        lval_t;
    typedef logic [HL-1:0][W-1:0] hdat_t;
    typedef logic [HL-1:0]        hval_t;

    // {strap[2:0], mode[1:0], active[1:0], err}
    localparam logic [7:0] VEC [0:5] = '{
        {3'b111, 2'd0, 2'b01, 1'b0},
        {3'b110, 2'd1, 2'b01, 1'b0},
        {3'b101, 2'd2, 2'b11, 1'b0},
        {3'b100, 2'd3, 2'b11, 1'b0},
        {3'b011, 2'd0, 2'b01, 1'b1},
        {3'b000, 2'd0, 2'b01, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] strap = 3'b000;
    ldat_t a_tx_d = '0;  lval_t a_tx_v = '0;
    hdat_t b_tx_d = '0;  hval_t b_tx_v = '0;
    ldat_t phy_rx_d = '0; lval_t phy_rx_v = '0;
    ldat_t phy_tx_d; lval_t phy_tx_v;
    ldat_t a_rx_d;   lval_t a_rx_v;
    hdat_t b_rx_d;   hval_t b_rx_v;
    logic [1:0] mode, active;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lane_bifurcation_mapper #(.NUM_LANES(NL), .DATA_W(W)) dut (
        .clk(clk), .rst(rst), .strap(strap),
        .a_tx_data(a_tx_d), .a_tx_valid(a_tx_v),
        .b_tx_data(b_tx_d), .b_tx_valid(b_tx_v),
        .phy_tx_data(phy_tx_d), .phy_tx_valid(phy_tx_v),
        .phy_rx_data(phy_rx_d), .phy_rx_valid(phy_rx_v),
        .a_rx_data(a_rx_d), .a_rx_valid(a_rx_v),
        .b_rx_data(b_rx_d), .b_rx_valid(b_rx_v),
        .mode(mode), .ctrl_active(active), .strap_err(err)
    );

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirement text
    function automatic void model_tx(input logic [1:0] m, input ldat_t ad, input lval_t av,
                                     input hdat_t bd, input hval_t bv,
                                     output ldat_t pd, output lval_t pv);
        for (int p = 0; p < NL; p++) begin
            case (m)
                2'd0: begin pd[p] = ad[p]; pv[p] = av[p]; end
                2'd1: begin pd[p] = ad[NL-1-p]; pv[p] = av[NL-1-p]; end
                2'd2: if (p < HL) begin pd[p] = ad[p]; pv[p] = av[p]; end
                      else begin pd[p] = bd[p-HL]; pv[p] = bv[p-HL]; end
                default: if (p < HL) begin pd[p] = bd[HL-1-p]; pv[p] = bv[HL-1-p]; end
                      else begin pd[p] = ad[NL-1-p]; pv[p] = av[NL-1-p]; end
            endcase
        end
    endfunction

    function automatic void model_rx(input logic [1:0] m, input ldat_t pd, input lval_t pv,
                                     output ldat_t ad, output lval_t av,
                                     output hdat_t bd, output hval_t bv);
        ad = '0; av = '0; bd = '0; bv = '0;
        for (int l = 0; l < NL; l++) begin
            case (m)
                2'd0: begin ad[l] = pd[l]; av[l] = pv[l]; end
                2'd1: begin ad[l] = pd[NL-1-l]; av[l] = pv[NL-1-l]; end
                2'd2: if (l < HL) begin
                          ad[l] = pd[l]; av[l] = pv[l];
                          bd[l] = pd[HL+l]; bv[l] = pv[HL+l];
                      end
                default: if (l < HL) begin
                          ad[l] = pd[NL-1-l]; av[l] = pv[NL-1-l];
                          bd[l] = pd[HL-1-l]; bv[l] = pv[HL-1-l];
                      end
            endcase
        end
    endfunction

    task automatic drive(input int seed);
        for (int l = 0; l < NL; l++) begin
            a_tx_d[l]   = W'(seed * 16 + l);
            phy_rx_d[l] = W'(8'h55 + seed * 3 + l * 7);
        end
        for (int l = 0; l < HL; l++) b_tx_d[l] = W'(8'hC0 ^ (seed * 8 + l));
        a_tx_v   = NL'(seed * 16'h03A5 ^ 16'h5A5A);
        b_tx_v   = HL'(seed * 37);
        phy_rx_v = NL'(seed * 16'h01F3);
    endtask

    task automatic check_all(input string req, input logic [1:0] m);
        ldat_t pd, ad; lval_t pv, av; hdat_t bd; hval_t bv;
        model_tx(m, a_tx_d, a_tx_v, b_tx_d, b_tx_v, pd, pv);
        model_rx(m, phy_rx_d, phy_rx_v, ad, av, bd, bv);
        chk(req, "phy_tx_data",  128'(phy_tx_d), 128'(pd));
        chk(req, "phy_tx_valid", 128'(phy_tx_v), 128'(pv));
        chk(req, "a_rx_data",    128'(a_rx_d),   128'(ad));
        chk(req, "a_rx_valid",   128'(a_rx_v),   128'(av));
        chk(req, "b_rx_data",    128'(b_rx_d),   128'(bd));
        chk(req, "b_rx_valid",   128'(b_rx_v),   128'(bv));
    endtask

    task automatic do_reset(input logic [2:0] s_hold, input logic [2:0] s_rel);
        @(negedge clk);
        rst = 1'b1; strap = s_hold;
        repeat (3) @(negedge clk);
        rst = 1'b0; strap = s_rel;   // captured at the next rising edge
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with a non-default strap present
        strap = 3'b100;
        drive(5);
        repeat (3) @(negedge clk);
        chk("R1", "mode",         128'(mode),     128'(2'd0));
        chk("R1", "ctrl_active",  128'(active),   128'(2'b01));
        chk("R1", "strap_err",    128'(err),      128'(1'b0));
        chk("R1", "phy_tx_valid", 128'(phy_tx_v), 128'(0));
        chk("R1", "a_rx_data",    128'(a_rx_d),   128'(0));
        chk("R1", "b_rx_valid",   128'(b_rx_v),   128'(0));

        // Table walk: every strap pattern, three lane patterns each
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v;
            string      req;
            v = VEC[i];
            do_reset(v[7:5], v[7:5]);
            req = v[0] ? "R9" : (v[4:3] == 2'd0 ? "R3" : v[4:3] == 2'd1 ? "R4" :
                                 v[4:3] == 2'd2 ? "R5" : "R6");
            chk(req,   "mode",        128'(mode),   128'(v[4:3]));
            chk("R11", "ctrl_active", 128'(active), 128'(v[2:1]));
            chk("R9",  "strap_err",   128'(err),    128'(v[0]));
            for (int s = 1; s <= 3; s++) begin
                drive(s + i * 4);
                @(negedge clk);
                check_all(req, v[4:3]);
            end
        end

        // R2: strap held at 3'b100 in reset, changed to 3'b111 at release
        do_reset(3'b100, 3'b111);
        chk("R2", "mode at release", 128'(mode), 128'(2'd0));
        strap = 3'b100;
        repeat (5) @(negedge clk);
        chk("R2", "mode after strap change",   128'(mode),   128'(2'd0));
        chk("R2", "active after strap change", 128'(active), 128'(2'b01));
        drive(9);
        @(negedge clk);
        check_all("R2", 2'd0);

        // R10: one edge of latency, old word held until the edge
        begin
            ldat_t pd_old, pd_new, ad; lval_t pv_old, pv_new, av; hdat_t bd; hval_t bv;
            model_tx(2'd0, a_tx_d, a_tx_v, b_tx_d, b_tx_v, pd_old, pv_old);
            drive(11);
            model_tx(2'd0, a_tx_d, a_tx_v, b_tx_d, b_tx_v, pd_new, pv_new);
            model_rx(2'd0, phy_rx_d, phy_rx_v, ad, av, bd, bv);
            #1;
            chk("R10", "tx data before edge",  128'(phy_tx_d), 128'(pd_old));
            chk("R10", "tx valid before edge", 128'(phy_tx_v), 128'(pv_old));
            @(negedge clk);
            chk("R10", "tx data after edge",   128'(phy_tx_d), 128'(pd_new));
            chk("R10", "tx valid after edge",  128'(phy_tx_v), 128'(pv_new));
            chk("R10", "rx valid after edge",  128'(a_rx_v),   128'(av));
        end

        // R7: single wide link ignores B transmit inputs, B receive idle
        begin
            ldat_t pd0; lval_t pv0;
            pd0 = phy_tx_d; pv0 = phy_tx_v;
            b_tx_d = ~b_tx_d; b_tx_v = ~b_tx_v;
            @(negedge clk);
            chk("R7", "phy_tx_data with B changed",  128'(phy_tx_d), 128'(pd0));
            chk("R7", "phy_tx_valid with B changed", 128'(phy_tx_v), 128'(pv0));
            phy_rx_v = '1;
            @(negedge clk);
            chk("R7", "b_rx_valid", 128'(b_rx_v), 128'(0));
            chk("R7", "b_rx_data",  128'(b_rx_d), 128'(0));
        end

        // R8: split layout ignores A transmit lanes 8..15, A rx upper idle
        do_reset(3'b101, 3'b101);
        drive(13);
        @(negedge clk);
        begin
            ldat_t pd0; lval_t pv0;
            pd0 = phy_tx_d; pv0 = phy_tx_v;
            for (int l = HL; l < NL; l++) a_tx_d[l] = ~a_tx_d[l];
            a_tx_v[NL-1:HL] = ~a_tx_v[NL-1:HL];
            phy_rx_v = '1;
            @(negedge clk);
            chk("R8", "phy_tx_data with A upper changed",  128'(phy_tx_d), 128'(pd0));
            chk("R8", "phy_tx_valid with A upper changed", 128'(phy_tx_v), 128'(pv0));
            chk("R8", "a_rx_valid upper", 128'(a_rx_v[NL-1:HL]), 128'(0));
        end

        // R1: a fresh reset returns outputs to zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mode in reset",         128'(mode),     128'(2'd0));
        chk("R1", "phy_tx_valid in reset", 128'(phy_tx_v), 128'(0));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule